// File: doc/BRIEF.md
# 1-Wire ROM Reader

This block is a single-master controller for a 1-Wire bus. The data line is open drain, so the block only ever pulls it low or lets it go. It reads the line back through a two-flop synchronizer. When `start` is pulsed, the block runs one complete transaction with no further help:

1. It drives a long reset low pulse.
2. It listens for a device answering with a presence pulse.
3. It shifts out the read-identity command byte 0x33, least significant bit first.
4. It reads back the 64-bit device identity in 64 read slots.

A running CRC-8 is updated with each identity bit as it arrives. When the transaction ends, the family code and the 48-bit serial number are placed on the outputs, along with the CRC verdict.

All slot timing is counted in ticks. One tick lasts `TICK_DIV` system clocks, so a tick of about 1 µs can be built from any clock. The `overdrive` input selects a second set of durations that are ten times shorter. The block captures this input when the transaction starts.

Top module: `owire_rom_reader`

## Requirements
- R1: After reset, `bus_pull` is 0. `busy`, `done`, `presence_err`, `crc_err` and `id_valid` are all 0, and `family` and `serial` read zero.
- R2: A transaction starts with a reset low pulse. In standard mode it lasts exactly 480 ticks, and one tick is `TICK_DIV` clocks.
- R3: The line is sampled 70 ticks after the reset pulse is released (7 ticks in overdrive). If the line is high at that point, the transaction ends with `done` and `presence_err`=1, `id_valid`=0 and `crc_err`=0. No further low pulse follows.
- R4: After a presence pulse, the byte 0x33 is written least significant bit first. A 1 bit is a 6-tick low pulse and a 0 bit is a 60-tick low pulse, each in a 70-tick slot. In overdrive these are 1, 6 and 7 ticks.
- R5: Next come 64 read slots. Each has a 6-tick low pulse (1 in overdrive), and the line is sampled 15 ticks after the slot starts (2 in overdrive). A high line reads as 1. The first bit read is identity bit 0.
- R6: At the end, `family` holds identity bits 7:0 and `serial` holds identity bits 55:8.
- R7: The CRC register starts at zero. For each bit b, it computes fb = crc[0] xor b, shifts right by one, and XORs in 0x8C when fb is 1; this is polynomial x^8+x^5+x^4+1, bit-reflected. If the value is zero after all 64 bits, then `id_valid`=1 and `crc_err`=0. Otherwise `crc_err`=1 and `id_valid`=0.
- R8: `done` is high for exactly one clock at the end of a transaction. `busy` is high from the clock after `start` is accepted until `done`, and low after it.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running transaction, its number of low pulses and its results are unchanged.
- R10: When `overdrive`=1 is captured at start, every duration is one tenth of its standard value; the reset pulse is 48 ticks. A change on `overdrive` during a transaction has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start-of-transaction pulse |
| overdrive | input | 1 | 1 selects the short timing set, captured at start |
| bus_in | input | 1 | Sensed level of the 1-Wire line |
| bus_pull | output | 1 | 1 drives the line low through the open-drain pad |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock end-of-transaction strobe |
| presence_err | output | 1 | No device answered the reset pulse |
| crc_err | output | 1 | Identity failed the CRC check |
| id_valid | output | 1 | Identity read and CRC correct |
| family | output | 8 | Family code, identity bits 7:0 |
| serial | output | 48 | Serial number, identity bits 55:8 |

## Verification
The bench acts as the device on the line. It answers with a presence pulse, decodes the command bits from the length of each low pulse, and answers the read slots from a stored identity.

The identities are tried in several forms:
- A correctly signed identity checks that the bits are assembled in the right order and that the CRC verdict is right.
- The same kind of identity with one family bit flipped after signing shows that the CRC covers the data bits and not only the check byte.
- A silent bus separates the presence-fail exit from a normal read.

Each form is run in both timing modes, and the reset pulse length is measured, which shows the two timing sets apart. A restart request and a mode change in the middle of a run show whether the captured settings stay in force.

// File: rtl/owm_pkg.sv
package owm_pkg;

  localparam int CNT_W   = 10;
  localparam int ID_BITS = 64;
  localparam logic [7:0] READ_ROM_CMD = 8'h33;

  typedef enum logic [1:0] {OP_RESET, OP_WRITE, OP_READ} op_e;

  // durations in ticks, counted from the start of the slot
  typedef struct packed {
    logic [CNT_W-1:0] low;   // tick count at which the line is released
    logic [CNT_W-1:0] samp;  // tick count at which the line is sampled
    logic [CNT_W-1:0] fin;   // tick count at which the slot ends
  } slot_t;

  function automatic slot_t slot_plan(op_e op, logic wbit, logic od);
    slot_t p;
    p = '0;
    case (op)
      OP_RESET: begin
        p.low  = od ? CNT_W'(48) : CNT_W'(480);
        p.samp = od ? CNT_W'(55) : CNT_W'(550);
        p.fin  = od ? CNT_W'(96) : CNT_W'(960);
      end
      OP_WRITE: begin
        if (wbit) p.low = od ? CNT_W'(1) : CNT_W'(6);
        else      p.low = od ? CNT_W'(6) : CNT_W'(60);
        p.samp = '0;
        p.fin  = od ? CNT_W'(7) : CNT_W'(70);
      end
      default: begin
        p.low  = od ? CNT_W'(1) : CNT_W'(6);
        p.samp = od ? CNT_W'(2) : CNT_W'(15);
        p.fin  = od ? CNT_W'(7) : CNT_W'(70);
      end
    endcase
    return p;
  endfunction

  // one step of the bit-reflected CRC-8, x^8 + x^5 + x^4 + 1
  function automatic logic [7:0] crc8_next(logic [7:0] c, logic b);
    logic       fb;
    logic [7:0] n;
    fb = c[0] ^ b;
    n  = c >> 1;
    if (fb) n = n ^ 8'h8C;
    return n;
  endfunction

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  op_e  op,
  input  logic wbit,
  input  logic od,
  input  logic tick,
  input  logic bus_in,
  output logic pull,
  output logic fin,
  output logic rbit
);
  logic             sync1, line;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_n;
  slot_t            plan_q;
  op_e              op_q;

  // named slot events, used by the logic and by the checks
  logic ev_release, ev_sample, ev_end;

  assign cnt_n      = cnt + 1'b1;
  assign ev_release = active && tick && (cnt_n == plan_q.low);
  assign ev_sample  = active && tick && (op_q != OP_WRITE) && (cnt_n == plan_q.samp);
  assign ev_end     = active && tick && (cnt_n == plan_q.fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      line  <= 1'b1;
    end else begin
      sync1 <= bus_in;
      line  <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      pull   <= 1'b0;
      fin    <= 1'b0;
      rbit   <= 1'b0;
      plan_q <= '0;
      op_q   <= OP_RESET;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        pull   <= 1'b1;
        plan_q <= slot_plan(op, wbit, od);
        op_q   <= op;
      end else if (active && tick) begin
        cnt <= cnt_n;
        if (ev_release) pull <= 1'b0;
        if (ev_sample)  rbit <= (op_q == OP_RESET) ? !line : line;
        if (ev_end) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  p_slot_opens_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> pull);
  p_released_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !pull);
  p_idle_no_pull_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !go) |=> !pull);
  p_sample_before_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |-> !ev_sample);

endmodule

// File: rtl/owire_rom_reader.sv
module owire_rom_reader
  import owm_pkg::*;
#(
  parameter int TICK_DIV = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        overdrive,
  input  logic        bus_in,
  output logic        bus_pull,
  output logic        busy,
  output logic        done,
  output logic        presence_err,
  output logic        crc_err,
  output logic        id_valid,
  output logic [7:0]  family,
  output logic [47:0] serial
);
  localparam int IDX_W = $clog2(ID_BITS);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_CMD, S_ROM} seq_e;

  seq_e               state;
  logic               od_q;
  logic [IDX_W-1:0]   idx;
  logic [ID_BITS-1:0] id_sr, id_n;
  logic [7:0]         crc, crc_n;
  logic               go, wbit;
  op_e                op;
  logic               tick, fin, rbit;

  owm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(go), .tick(tick)
  );

  owm_slot_engine u_slot (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .wbit(wbit), .od(od_q),
    .tick(tick), .bus_in(bus_in), .pull(bus_pull), .fin(fin), .rbit(rbit)
  );

  assign id_n  = {rbit, id_sr[ID_BITS-1:1]};
  assign crc_n = crc8_next(crc, rbit);
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      od_q         <= 1'b0;
      idx          <= '0;
      id_sr        <= '0;
      crc          <= '0;
      go           <= 1'b0;
      wbit         <= 1'b0;
      op           <= OP_RESET;
      done         <= 1'b0;
      presence_err <= 1'b0;
      crc_err      <= 1'b0;
      id_valid     <= 1'b0;
      family       <= '0;
      serial       <= '0;
    end else begin
      done <= 1'b0;
      go   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state        <= S_RST;
          od_q         <= overdrive;
          op           <= OP_RESET;
          go           <= 1'b1;
          idx          <= '0;
          crc          <= '0;
          presence_err <= 1'b0;
          crc_err      <= 1'b0;
          id_valid     <= 1'b0;
        end
        S_RST: if (fin) begin
          if (rbit) begin
            state <= S_CMD;
            op    <= OP_WRITE;
            wbit  <= READ_ROM_CMD[0];
            go    <= 1'b1;
          end else begin
            presence_err <= 1'b1;
            done         <= 1'b1;
            state        <= S_IDLE;
          end
        end
        S_CMD: if (fin) begin
          go <= 1'b1;
          if (idx[2:0] == 3'd7) begin
            state <= S_ROM;
            op    <= OP_READ;
            idx   <= '0;
          end else begin
            idx  <= idx + 1'b1;
            wbit <= READ_ROM_CMD[idx[2:0] + 3'd1];
          end
        end
        S_ROM: if (fin) begin
          id_sr <= id_n;
          crc   <= crc_n;
          if (idx == IDX_W'(ID_BITS - 1)) begin
            family   <= id_n[7:0];
            serial   <= id_n[55:8];
            crc_err  <= (crc_n != 8'h00);
            id_valid <= (crc_n == 8'h00);
            done     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            go  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_fail_no_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && presence_err) |-> (!id_valid && !crc_err));
  p_crc_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !presence_err) |-> (crc_err != id_valid));
  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(od_q));
  p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));

endmodule

// File: tb/sim_owire_rom_reader.sv
module sim_owire_rom_reader;
  localparam int TDIV = 4;

  // one time unit is 1 ns: 4 ns period, 250 MHz
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, overdrive, slave_pull;
  logic        bus_in, bus_pull, busy, done, presence_err, crc_err, id_valid;
  logic [7:0]  family;
  logic [47:0] serial;

  assign bus_in = !(bus_pull || slave_pull);

  owire_rom_reader #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .overdrive(overdrive),
    .bus_in(bus_in), .bus_pull(bus_pull), .busy(busy), .done(done),
    .presence_err(presence_err), .crc_err(crc_err), .id_valid(id_valid),
    .family(family), .serial(serial)
  );

  int checks = 0, fails = 0;
  int pull_edges = 0, done_cnt = 0, rst_len = 0;
  logic [7:0] cmd_seen;

  always @(posedge bus_pull) pull_edges++;
  always @(posedge clk) if (done) done_cnt++;

  // fields: data56, overdrive, device present, flip family bit 5 after signing
  localparam logic [58:0] VEC [0:5] = '{
    {56'h00000B3A9C5128, 1'b0, 1'b1, 1'b0},
    {56'hFFEEDDCCBBAA01, 1'b0, 1'b1, 1'b1},
    {56'h123456789ABC10, 1'b1, 1'b1, 1'b0},
    {56'h800000000000FE, 1'b1, 1'b1, 1'b1},
    {56'h5A5A5A5A5A5A5A, 1'b0, 1'b0, 1'b0},
    {56'h0F0F0F0F0F0F22, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reflected CRC-8 written with explicit tap positions
  function automatic logic [7:0] crc_ref(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c  = {fb, c[7:1]};
      c[3] = c[3] ^ fb;
      c[2] = c[2] ^ fb;
    end
    return c;
  endfunction

  task automatic measure_low(output int len);
    len = 0;
    do begin
      @(negedge clk);
      if (bus_pull) len++;
    end while (bus_pull);
  endtask

  task automatic slave(input logic [63:0] rom, input bit present, input bit od);
    int len;
    @(posedge bus_pull);
    measure_low(len);
    rst_len = len;
    if (!present) return;
    repeat (od ? 8 : 120) @(negedge clk);
    slave_pull = 1'b1;
    repeat (od ? 40 : 400) @(negedge clk);
    slave_pull = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge bus_pull);
      measure_low(len);
      cmd_seen[i] = (len < (od ? 12 : 120));
    end
    for (int i = 0; i < 64; i++) begin
      @(posedge bus_pull);
      if (!rom[i]) begin
        slave_pull = 1'b1;
        repeat (od ? 12 : 120) @(negedge clk);
        slave_pull = 1'b0;
      end
    end
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input logic [55:0] d, input bit od, input bit present,
                     input bit corrupt, input bit disturb);
    logic [63:0] rom;
    int edges0, dones0;
    rom = {crc_ref(d), d};
    if (corrupt) rom[5] = ~rom[5];
    edges0 = pull_edges;
    dones0 = done_cnt;
    cmd_seen = 8'h00;
    overdrive = od;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
    fork
      slave(rom, present, od);
      begin
        if (disturb) begin
          repeat (50) @(negedge clk);
          start = 1'b1; overdrive = ~od;
          @(negedge clk) start = 1'b0;
        end
        wait_done();
      end
    join
    // R2 / R10: reset pulse length in clocks
    chk(rst_len == (od ? 48 : 480) * TDIV, od ? "R10" : "R2", "reset low clocks",
        64'(rst_len), 64'((od ? 48 : 480) * TDIV));
    chk(presence_err == !present, "R3", "presence_err", 64'(presence_err), 64'(!present));
    if (present) begin
      chk(cmd_seen == 8'h33, "R4", "command byte", 64'(cmd_seen), 64'h33);
      chk(family == rom[7:0], "R6", "family", 64'(family), 64'(rom[7:0]));
      chk(serial == rom[55:8], "R5", "serial bits", 64'(serial), 64'(rom[55:8]));
      chk(crc_err == corrupt, "R7", "crc_err", 64'(crc_err), 64'(corrupt));
      chk(id_valid == !corrupt, "R7", "id_valid", 64'(id_valid), 64'(!corrupt));
    end else begin
      chk(id_valid == 1'b0 && crc_err == 1'b0, "R3", "flags on silent bus",
          64'({id_valid, crc_err}), 64'd0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", 64'(done), 64'd0);
    chk(busy == 1'b0, "R8", "busy after done", 64'(busy), 64'd0);
    repeat (300) @(negedge clk);
    chk(pull_edges - edges0 == (present ? 73 : 1), disturb ? "R9" : "R3",
        "low pulse count", 64'(pull_edges - edges0), 64'(present ? 73 : 1));
    chk(done_cnt - dones0 == 1, disturb ? "R9" : "R8", "done count",
        64'(done_cnt - dones0), 64'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; overdrive = 1'b0; slave_pull = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state right after reset
    chk(bus_pull == 1'b0, "R1", "bus_pull", 64'(bus_pull), 64'd0);
    chk({busy, done, presence_err, crc_err, id_valid} == 5'b0, "R1", "flags",
        64'({busy, done, presence_err, crc_err, id_valid}), 64'd0);
    chk(family == 8'h00 && serial == 48'h0, "R1", "id outputs",
        64'({family, serial}), 64'd0);

    for (int v = 0; v < 6; v++)
      run(VEC[v][58:3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);

    // R9 and R10: restart request and mode flip in the middle of a run
    run(56'hC0FFEE12345677, 1'b1, 1'b1, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule